// File: doc/BRIEF.md
# Register Window Index Flattener

This block turns an architectural integer register number into an address in a flat physical register array that holds several banks of global registers, a ring of overlapping register windows and a small set of microcode scratch registers. A lookup uses two pieces of context held inside the block: the current window pointer, which picks the window that the windowed registers rotate onto, and the global level, which picks one bank of eight globals.

Beyond the normal architectural range, the index space carries a microcode range and two alias ranges. Each alias range repeats the architectural layout, but its windowed registers resolve against the window before or the window after the current one. Indices past the last alias range are rejected with an illegal flag instead of an address. Lookups go in with a valid strobe and, in the default build, come out one cycle later from a register stage. The two context values change through their own write ports.

Top module: `idx_flat_top`

With the default parameters (8 windows, global levels 0 to 3, 32 architectural and 8 microcode registers) there are 32 global slots at physical 0 to 31, a window ring of 128 slots at 32 to 159, and microcode slots at 160 to 167.

## Requirements
- R1: Index 0 to 7 is a global. It maps to index + 8*GL, so each global level owns its own bank of eight.
- R2: Index 8 to 31 is windowed. It maps to 32 + ((index - 8 - 16*CWP) mod 128), which gives 16 new slots per window and wraps around the ring.
- R3: Index 32 to 39 is a microcode register. It maps to index - 32 + 160, above all window storage.
- R4: Index 40 to 71 is the previous-window alias, with local = index - 40. A local below 8 maps as the R1 global. Any other local maps as R2 but with CWP-1, and CWP 0 wraps to window 7.
- R5: Index 72 to 103 is the next-window alias, with local = index - 72. A local below 8 maps as the R1 global. Any other local maps as R2 but with CWP+1, and CWP 7 wraps to window 0.
- R6: An index of 104 or above raises illegal_o and gives phys_idx_o = 0.
- R7: A lookup taken with in_valid_i high shows its result one cycle later with out_valid_o high. A cycle with in_valid_i low gives out_valid_o, illegal_o and phys_idx_o all 0 one cycle later.
- R8: A CWP or GL write takes effect for lookups from the next cycle on. A lookup issued in the same cycle as the write still uses the old value.
- R9: Reset clears CWP and GL to 0 and out_valid_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cwp_we_i | input | 1 | Write strobe for the window pointer |
| cwp_wdata_i | input | 3 | New window pointer |
| gl_we_i | input | 1 | Write strobe for the global level |
| gl_wdata_i | input | 2 | New global level |
| in_valid_i | input | 1 | Lookup request strobe |
| idx_i | input | 7 | Architectural register index |
| out_valid_o | output | 1 | Result valid |
| phys_idx_o | output | 8 | Physical register index |
| illegal_o | output | 1 | Index out of range |

## Verification
Some properties are checked by assertions on every cycle. An accepted lookup yields a valid result on the next cycle. Idle cycles leave all outputs at zero. An illegal index never carries an address. Any mapped address stays inside the physical array. Context writes land on the next cycle, and context holds when no write is made. The exact address arithmetic can only be shown by the bench's scenarios. That covers the global banking, the ring rotation, the window wrap at 0 and 7 in the alias ranges, and the stale-context behaviour when a write and a lookup share a cycle. The bench walks every index under every window pointer and global level against its own model.

// File: rtl/idx_flat_pkg.sv
package idx_flat_pkg;
  localparam int GLOB_PER_LVL = 8;
  localparam int WIN_STRIDE   = 16;

  typedef enum logic [1:0] {
    K_GLOB  = 2'd0,
    K_WIN   = 2'd1,
    K_MICRO = 2'd2,
    K_BAD   = 2'd3
  } idx_kind_e;

  typedef enum logic [1:0] {
    SEL_CUR  = 2'd0,
    SEL_PREV = 2'd1,
    SEL_NEXT = 2'd2
  } win_sel_e;
endpackage

// File: rtl/idx_flat_ctx.sv
module idx_flat_ctx #(
  parameter int NWIN   = 8,
  parameter int MAX_GL = 3,
  parameter int CW     = 3,
  parameter int GW     = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cwp_we_i,
  input  logic [CW-1:0] cwp_wdata_i,
  input  logic          gl_we_i,
  input  logic [GW-1:0] gl_wdata_i,
  output logic [CW-1:0] cwp_o,
  output logic [GW-1:0] gl_o
);
  logic cwp_ok, gl_ok;
  // out-of-range values are dropped (only reachable for non power-of-two sizes)
  assign cwp_ok = int'(cwp_wdata_i) < NWIN;
  assign gl_ok  = int'(gl_wdata_i) <= MAX_GL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_o <= '0;
      gl_o  <= '0;
    end else begin
      if (cwp_we_i && cwp_ok) cwp_o <= cwp_wdata_i;
      if (gl_we_i && gl_ok)   gl_o  <= gl_wdata_i;
    end
  end

  p_cwp_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cwp_we_i && cwp_ok) |=> (cwp_o == $past(cwp_wdata_i)));
  p_cwp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cwp_we_i |=> $stable(cwp_o));
  p_gl_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gl_we_i && gl_ok) |=> (gl_o == $past(gl_wdata_i)));
  p_gl_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gl_we_i |=> $stable(gl_o));
endmodule

// File: rtl/idx_flat_decode.sv
module idx_flat_decode import idx_flat_pkg::*; #(
  parameter int NUM_ARCH  = 32,
  parameter int NUM_MICRO = 8,
  parameter int IW        = 7,
  parameter int LW        = 5
) (
  input  logic [IW-1:0] idx_i,
  output idx_kind_e     kind_o,
  output win_sel_e      sel_o,
  output logic [LW-1:0] loc_o
);
  localparam int B_MICRO = NUM_ARCH;
  localparam int B_PREV  = NUM_ARCH + NUM_MICRO;
  localparam int B_NEXT  = 2 * NUM_ARCH + NUM_MICRO;
  localparam int B_END   = 3 * NUM_ARCH + NUM_MICRO;

  always_comb begin
    int v;
    int rel;
    v      = int'(idx_i);
    rel    = v;
    kind_o = K_WIN;
    sel_o  = SEL_CUR;
    if (v < B_MICRO) begin
      rel = v;
    end else if (v < B_PREV) begin
      rel    = v - B_MICRO;
      kind_o = K_MICRO;
    end else if (v < B_NEXT) begin
      rel   = v - B_PREV;
      sel_o = SEL_PREV;
    end else if (v < B_END) begin
      rel   = v - B_NEXT;
      sel_o = SEL_NEXT;
    end else begin
      rel    = 0;
      kind_o = K_BAD;
    end
    if (kind_o == K_WIN && rel < GLOB_PER_LVL) kind_o = K_GLOB;
    loc_o = LW'(rel);
  end
endmodule

// File: rtl/idx_flat_rotate.sv
module idx_flat_rotate import idx_flat_pkg::*; #(
  parameter int NWIN = 8,
  parameter int CW   = 3,
  parameter int LW   = 5,
  parameter int RW   = 7
) (
  input  logic [CW-1:0] cwp_i,
  input  win_sel_e      sel_i,
  input  logic [LW-1:0] loc_i,
  output logic [RW-1:0] slot_o
);
  localparam int RING = NWIN * WIN_STRIDE;

  logic [CW-1:0] win;

  always_comb begin
    unique case (sel_i)
      SEL_PREV: win = (cwp_i == '0) ? CW'(NWIN - 1) : cwp_i - CW'(1);
      SEL_NEXT: win = (int'(cwp_i) == NWIN - 1) ? '0 : cwp_i + CW'(1);
      default:  win = cwp_i;
    endcase
  end

  // ring offset without a divider: bias by RING, then one conditional subtract
  always_comb begin
    int sum;
    sum = int'(loc_i) - GLOB_PER_LVL + RING - int'(win) * WIN_STRIDE;
    if (sum >= RING) sum = sum - RING;
    slot_o = RW'(sum);
  end
endmodule

// File: rtl/idx_flat_top.sv
module idx_flat_top import idx_flat_pkg::*; #(
  parameter int NWIN      = 8,
  parameter int MAX_GL    = 3,
  parameter int NUM_ARCH  = 32,
  parameter int NUM_MICRO = 8,
  parameter bit REG_OUT   = 1'b1,
  localparam int IDX_N    = 3 * NUM_ARCH + NUM_MICRO,
  localparam int NUM_GLOB = (MAX_GL + 1) * GLOB_PER_LVL,
  localparam int RING     = NWIN * WIN_STRIDE,
  localparam int PHYS_N   = NUM_GLOB + RING + NUM_MICRO,
  localparam int IW       = $clog2(IDX_N),
  localparam int PIW      = $clog2(PHYS_N),
  localparam int CW       = $clog2(NWIN),
  localparam int GW       = $clog2(MAX_GL + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cwp_we_i,
  input  logic [CW-1:0]  cwp_wdata_i,
  input  logic           gl_we_i,
  input  logic [GW-1:0]  gl_wdata_i,
  input  logic           in_valid_i,
  input  logic [IW-1:0]  idx_i,
  output logic           out_valid_o,
  output logic [PIW-1:0] phys_idx_o,
  output logic           illegal_o
);
  localparam int LW = $clog2(NUM_ARCH > NUM_MICRO ? NUM_ARCH : NUM_MICRO);
  localparam int RW = $clog2(RING);

  logic [CW-1:0]  cwp_q;
  logic [GW-1:0]  gl_q;
  idx_kind_e      kind;
  win_sel_e       sel;
  logic [LW-1:0]  loc;
  logic [RW-1:0]  slot;
  logic [PIW-1:0] phys_d;
  logic           bad_d;

  idx_flat_ctx #(.NWIN(NWIN), .MAX_GL(MAX_GL), .CW(CW), .GW(GW)) u_ctx (
    .clk_i, .rst_ni, .cwp_we_i, .cwp_wdata_i, .gl_we_i, .gl_wdata_i,
    .cwp_o(cwp_q), .gl_o(gl_q)
  );

  idx_flat_decode #(.NUM_ARCH(NUM_ARCH), .NUM_MICRO(NUM_MICRO), .IW(IW), .LW(LW)) u_dec (
    .idx_i, .kind_o(kind), .sel_o(sel), .loc_o(loc)
  );

  idx_flat_rotate #(.NWIN(NWIN), .CW(CW), .LW(LW), .RW(RW)) u_rot (
    .cwp_i(cwp_q), .sel_i(sel), .loc_i(loc), .slot_o(slot)
  );

  always_comb begin
    phys_d = '0;
    bad_d  = 1'b0;
    unique case (kind)
      K_GLOB:  phys_d = PIW'(int'(loc) + int'(gl_q) * GLOB_PER_LVL);
      K_WIN:   phys_d = PIW'(NUM_GLOB + int'(slot));
      K_MICRO: phys_d = PIW'(NUM_GLOB + RING + int'(loc));
      default: bad_d  = 1'b1;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          out_valid_o <= 1'b0;
          phys_idx_o  <= '0;
          illegal_o   <= 1'b0;
        end else begin
          out_valid_o <= in_valid_i;
          phys_idx_o  <= in_valid_i ? phys_d : '0;
          illegal_o   <= in_valid_i & bad_d;
        end
      end

      p_valid_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);
      p_idle_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);
      p_flag_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && int'(idx_i) >= IDX_N) |=> illegal_o);
      p_flag_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && int'(idx_i) < IDX_N) |=> !illegal_o);
    end else begin : g_comb
      assign out_valid_o = in_valid_i;
      assign phys_idx_o  = in_valid_i ? phys_d : '0;
      assign illegal_o   = in_valid_i & bad_d;
    end
  endgenerate

  p_no_map_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && illegal_o) |-> (phys_idx_o == '0));
  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (!illegal_o && phys_idx_o == '0));
  p_in_array_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !illegal_o) |-> (int'(phys_idx_o) < PHYS_N));
endmodule

// File: tb/idx_flat_top_test.sv
module idx_flat_top_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cwp_we_i = 1'b0;
  logic [2:0] cwp_wdata_i = '0;
  logic       gl_we_i = 1'b0;
  logic [1:0] gl_wdata_i = '0;
  logic       in_valid_i = 1'b0;
  logic [6:0] idx_i = '0;
  logic       out_valid_o;
  logic [7:0] phys_idx_o;
  logic       illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  idx_flat_top uut (
    .clk_i, .rst_ni, .cwp_we_i, .cwp_wdata_i, .gl_we_i, .gl_wdata_i,
    .in_valid_i, .idx_i, .out_valid_o, .phys_idx_o, .illegal_o
  );

  // {cwp, gl, idx, phys, illegal}
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {3'd0, 2'd0, 7'd3,   8'd3,   1'b0},  // R1
    {3'd5, 2'd3, 7'd7,   8'd31,  1'b0},  // R1
    {3'd0, 2'd0, 7'd8,   8'd32,  1'b0},  // R2
    {3'd0, 2'd1, 7'd31,  8'd55,  1'b0},  // R2
    {3'd1, 2'd0, 7'd8,   8'd144, 1'b0},  // R2 wrap
    {3'd7, 2'd2, 7'd31,  8'd71,  1'b0},  // R2
    {3'd4, 2'd1, 7'd32,  8'd160, 1'b0},  // R3
    {3'd4, 2'd1, 7'd39,  8'd167, 1'b0},  // R3
    {3'd0, 2'd0, 7'd48,  8'd48,  1'b0},  // R4 cwp 0 -> 7
    {3'd4, 2'd2, 7'd45,  8'd21,  1'b0},  // R4 global
    {3'd7, 2'd0, 7'd80,  8'd32,  1'b0},  // R5 cwp 7 -> 0
    {3'd3, 2'd0, 7'd103, 8'd119, 1'b0},  // R5
    {3'd2, 2'd1, 7'd100, 8'd132, 1'b0},  // R5
    {3'd2, 2'd1, 7'd74,  8'd10,  1'b0},  // R5 global
    {3'd0, 2'd0, 7'd104, 8'd0,   1'b1},  // R6
    {3'd6, 2'd3, 7'd127, 8'd0,   1'b1}   // R6
  };

  function automatic void ref_map(input int idx, input int cwp, input int gl,
                                  output int ph, output bit ill);
    int loc;
    int w;
    ph = 0; ill = 1'b0; w = cwp; loc = 0;
    if (idx < 32) loc = idx;
    else if (idx < 40) begin ph = idx - 32 + 160; return; end
    else if (idx < 72) begin loc = idx - 40; w = cwp - 1; end
    else if (idx < 104) begin loc = idx - 72; w = cwp + 1; end
    else begin ill = 1'b1; return; end
    if (loc < 8) ph = loc + gl * 8;
    else ph = 32 + ((((loc - 8 - w * 16) % 128) + 128) % 128);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_ctx(input int cwp, input int gl);
    @(negedge clk_i);
    cwp_we_i = 1'b1; cwp_wdata_i = 3'(cwp);
    gl_we_i = 1'b1;  gl_wdata_i = 2'(gl);
    @(negedge clk_i);
    cwp_we_i = 1'b0; gl_we_i = 1'b0;
  endtask

  // result is sampled at the negedge after the capturing posedge
  task automatic lookup(input int idx);
    @(negedge clk_i);
    in_valid_i = 1'b1; idx_i = 7'(idx);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ph;
    bit ill;
    #12;
    check("R9 valid in reset", int'(out_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 valid after reset", int'(out_valid_o), 0);
    lookup(0);
    check("R9 gl cleared", int'(phys_idx_o), 0);
    lookup(8);
    check("R9 cwp cleared", int'(phys_idx_o), 32);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      set_ctx(int'(v[20:18]), int'(v[17:16]));
      lookup(int'(v[15:9]));
      check($sformatf("R1-6 vec %0d valid", i), int'(out_valid_o), 1);
      check($sformatf("vec %0d phys (R1 R2 R3 R4 R5)", i), int'(phys_idx_o), int'(v[8:1]));
      check($sformatf("vec %0d illegal (R6)", i), int'(illegal_o), int'(v[0]));
    end

    // R7: idle cycle clears outputs
    @(negedge clk_i);
    check("R7 idle valid", int'(out_valid_o), 0);
    check("R7 idle phys", int'(phys_idx_o), 0);
    check("R7 idle illegal", int'(illegal_o), 0);

    // R8: write and lookup in the same cycle use the old context
    set_ctx(2, 1);
    @(negedge clk_i);
    cwp_we_i = 1'b1; cwp_wdata_i = 3'd5;
    gl_we_i = 1'b1;  gl_wdata_i = 2'd3;
    in_valid_i = 1'b1; idx_i = 7'd8;
    @(negedge clk_i);
    cwp_we_i = 1'b0; gl_we_i = 1'b0;
    idx_i = 7'd2;
    check("R8 old cwp", int'(phys_idx_o), 128);
    @(negedge clk_i);
    in_valid_i = 1'b1; idx_i = 7'd8;
    check("R8 new gl", int'(phys_idx_o), 26);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check("R8 new cwp", int'(phys_idx_o), 80);

    // exhaustive sweep over all contexts and indices
    for (int g = 0; g < 4; g++) begin
      for (int c = 0; c < 8; c++) begin
        set_ctx(c, g);
        for (int x = 0; x < 128; x++) begin
          lookup(x);
          ref_map(x, c, g, ph, ill);
          if (out_valid_o !== 1'b1 || int'(phys_idx_o) != ph || illegal_o !== ill) begin
            check($sformatf("R1 R2 R3 R4 R5 R6 R7 sweep idx %0d cwp %0d gl %0d", x, c, g),
                  {int'(out_valid_o), int'(illegal_o), int'(phys_idx_o)} == 0 ? -1 :
                  int'(phys_idx_o) + 256 * int'(illegal_o) + 512 * int'(out_valid_o),
                  ph + 256 * int'(ill) + 512);
          end else begin
            checks++;
          end
        end
      end
    end

    // reset mid-run returns context to zero (R9)
    set_ctx(6, 2);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R9 valid low in reset", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    lookup(1);
    check("R9 gl zero after reset", int'(phys_idx_o), 1);
    lookup(9);
    check("R9 cwp zero after reset", int'(phys_idx_o), 33);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule